// File: doc/BRIEF.md
# Power Delivery BMC Packet Transmitter

This block drives one USB Power Delivery packet onto a single CC line using biphase mark coding (BMC). A programmable divider of the kernel clock produces a half-bit tick, and each bit lasts two ticks. A send request first waits until the minimum interframe gap has passed since the previous frame ended. If the line is quiet at that moment, the block sends the whole frame in order: a 64-bit preamble, a programmable 20-bit start ordered set, the payload bytes coded as 4b5b symbols, a CRC-32 over the payload, and the end-of-packet code. If the line is busy at that moment, it drops the packet and raises a discard flag instead.

The payload comes in one byte at a time. The block raises a data request whenever its one-byte holding register is empty and more bytes are still owed, and a DMA engine or other agent answers each request by writing one byte. A frame cannot be aborted once started. Completion raises a sticky sent flag. Each flag has a clear strobe and an interrupt enable. All configuration inputs must be held stable from the send request until the frame ends.

Top module: `pd_bmc_tx`

## Requirements
- R1: After reset, `cc_o`, `cc_oe_o`, `busy_o`, `sent_o`, `disc_o`, `irq_o` and `data_req_o` are all low.
- R2: A half-bit lasts `cfg_hbit_div_i`+1 clocks. The line toggles at the start of every bit and toggles again at mid-bit only for a one. The first half of the first bit is high because the idle line is low.
- R3: A frame starts with 64 preamble bits alternating 0,1,0,... and then sends the 20 bits of `cfg_sop_i`, bit 0 first.
- R4: The frame then carries exactly the `cfg_len_i` payload bytes, with the length captured at the send request. Each byte is sent low nibble first, and each nibble is sent as its 5-bit code, bit 0 first. The codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Each byte is obtained by one `data_req_o` request, answered by one `data_we_i` write.
- R5: After the payload come four CRC bytes, coded like payload bytes with the low byte first, and then the end code 01101 sent bit 0 first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. One more half-bit follows with a final transition, after which `cc_oe_o` and `cc_o` go low.
- R6: A frame never starts sooner than (`cfg_gap_i`+1) half-bits after the previous frame's `cc_oe_o` fell. A send request made during the gap starts its frame at most three clocks after the gap ends.
- R7: If `line_busy_i` is high when the gap has elapsed, no frame is driven, no data is requested, `disc_o` is set and `busy_o` drops.
- R8: `busy_o` stays high from the send request until the frame ends or is discarded. A send request while busy is ignored and does not queue a second frame.
- R9: `sent_o` sets when a frame ends. Both flags stay set until their clear strobe. If a set and a clear arrive in the same cycle, the set wins.
- R10: `irq_o` is the OR of each flag gated by its own enable.
- R11: A zero-length payload sends no payload symbols and a CRC of 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_hbit_div_i | input | DIV_W | Half-bit period in clocks, minus one |
| cfg_gap_i | input | GAP_W | Interframe gap in half-bits, minus one |
| cfg_sop_i | input | 20 | Start ordered set, bit 0 sent first |
| cfg_len_i | input | LEN_W | Payload byte count |
| send_i | input | 1 | Send request strobe |
| line_busy_i | input | 1 | Receive in progress or line activity |
| data_i | input | 8 | Payload byte |
| data_we_i | input | 1 | Payload byte write strobe |
| data_req_o | output | 1 | Holding register empty and more bytes owed |
| ie_sent_i | input | 1 | Interrupt enable for sent |
| ie_disc_i | input | 1 | Interrupt enable for discarded |
| clr_sent_i | input | 1 | Clear strobe for sent flag |
| clr_disc_i | input | 1 | Clear strobe for discarded flag |
| busy_o | output | 1 | Send in progress |
| sent_o | output | 1 | Sticky message-sent flag |
| disc_o | output | 1 | Sticky message-discarded flag |
| irq_o | output | 1 | Interrupt request |
| cc_o | output | 1 | BMC line level |
| cc_oe_o | output | 1 | Line driver enable |

## Verification
The bench instantiates the block with DIV_W=8, GAP_W=8 and LEN_W=6. This allows payloads of up to 63 bytes, of which random frames use up to 12. At run time it uses three half-bit dividers. The value 13 gives 14-clock half-bits. The values 1 and 2 give two- and three-clock half-bits, which pack many random frames and both zero-length and long payloads into a short run. A gap setting of 5 makes the back-to-back start window small enough to measure to the clock.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_PRE, ST_SOP, ST_DATA, ST_CRC, ST_EOP, ST_TAIL
  } tx_state_e;

  localparam int          SOP_W     = 20;
  localparam logic [6:0]  PRE_BITS  = 7'd64;
  localparam logic [6:0]  SOP_BITS  = 7'd20;
  localparam logic [6:0]  BYTE_BITS = 7'd10;
  localparam logic [6:0]  END_BITS  = 7'd5;
  localparam logic [4:0]  END_CODE  = 5'b01101;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

  function automatic logic [4:0] enc_4b5b(input logic [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'b11110; 4'h1: c = 5'b01001; 4'h2: c = 5'b10100; 4'h3: c = 5'b10101;
      4'h4: c = 5'b01010; 4'h5: c = 5'b01011; 4'h6: c = 5'b01110; 4'h7: c = 5'b01111;
      4'h8: c = 5'b10010; 4'h9: c = 5'b10011; 4'hA: c = 5'b10110; 4'hB: c = 5'b10111;
      4'hC: c = 5'b11010; 4'hD: c = 5'b11011; 4'hE: c = 5'b11100; default: c = 5'b11101;
    endcase
    return c;
  endfunction

  // low nibble code sits in the bits shifted out first
  function automatic logic [9:0] enc_byte(input logic [7:0] b);
    return {enc_4b5b(b[7:4]), enc_4b5b(b[3:0])};
  endfunction

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/pd_hbit_timer.sv
module pd_hbit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R2
  hbit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pd_tx_flags.sv
module pd_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_sent_i,
  input  logic set_disc_i,
  input  logic clr_sent_i,
  input  logic clr_disc_i,
  input  logic ie_sent_i,
  input  logic ie_disc_i,
  output logic sent_o,
  output logic disc_o,
  output logic irq_o
);

  logic sent_q, disc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      if (set_sent_i)      sent_q <= 1'b1;
      else if (clr_sent_i) sent_q <= 1'b0;
      if (set_disc_i)      disc_q <= 1'b1;
      else if (clr_disc_i) disc_q <= 1'b0;
    end
  end

  assign sent_o = sent_q;
  assign disc_o = disc_q;
  assign irq_o  = (sent_q & ie_sent_i) | (disc_q & ie_disc_i);

  // R9
  clr_sent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sent_i && !set_sent_i) |=> !sent_q);

  // R7
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_sent_i && set_disc_i));

endmodule

// File: rtl/pd_bmc_tx.sv
module pd_bmc_tx
  import pd_tx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] cfg_hbit_div_i,
  input  logic [GAP_W-1:0] cfg_gap_i,
  input  logic [19:0]      cfg_sop_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             send_i,
  input  logic             line_busy_i,
  input  logic [7:0]       data_i,
  input  logic             data_we_i,
  output logic             data_req_o,
  input  logic             ie_sent_i,
  input  logic             ie_disc_i,
  input  logic             clr_sent_i,
  input  logic             clr_disc_i,
  output logic             busy_o,
  output logic             sent_o,
  output logic             disc_o,
  output logic             irq_o,
  output logic             cc_o,
  output logic             cc_oe_o
);

  localparam int GCNT_W = GAP_W + 1;

  tx_state_e         state_q;
  logic              line_q, oe_q, half_q;
  logic [6:0]        bcnt_q;
  logic [SOP_W-1:0]  shreg_q;
  logic [LEN_W-1:0]  len_q, byte_left_q, req_left_q;
  logic [31:0]       crc_q, crc_out;
  logic [1:0]        crc_idx_q, crc_idx_nxt;
  logic [7:0]        data_q, crc_nxt_byte;
  logic              data_full_q;
  logic [GCNT_W-1:0] gcnt_q;

  logic tick, in_frame, gap_ok, start_ev, disc_ev, end_ev;
  logic cur_bit, mid_tick, bnd_tick, seg_last, load_byte;

  assign in_frame  = (state_q != ST_IDLE) && (state_q != ST_WAIT);
  assign gap_ok    = gcnt_q > {1'b0, cfg_gap_i};
  assign start_ev  = (state_q == ST_WAIT) && gap_ok && !line_busy_i;
  assign disc_ev   = (state_q == ST_WAIT) && gap_ok && line_busy_i;
  assign end_ev    = (state_q == ST_TAIL) && tick;
  assign cur_bit   = (state_q == ST_PRE) ? bcnt_q[0] : shreg_q[0];
  assign mid_tick  = in_frame && (state_q != ST_TAIL) && tick && !half_q;
  assign bnd_tick  = in_frame && (state_q != ST_TAIL) && tick && half_q;
  assign seg_last  = (bcnt_q == 7'd1);
  assign load_byte = bnd_tick && seg_last && (byte_left_q != '0) &&
                     ((state_q == ST_SOP) || (state_q == ST_DATA));

  assign crc_out      = ~crc_q;
  assign crc_idx_nxt  = crc_idx_q + 2'd1;
  assign crc_nxt_byte = crc_out[{crc_idx_nxt, 3'b000} +: 8];

  pd_hbit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (start_ev | end_ev),
    .div_i     (cfg_hbit_div_i),
    .tick_o    (tick)
  );

  pd_tx_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_sent_i (end_ev),
    .set_disc_i (disc_ev),
    .clr_sent_i (clr_sent_i),
    .clr_disc_i (clr_disc_i),
    .ie_sent_i  (ie_sent_i),
    .ie_disc_i  (ie_disc_i),
    .sent_o     (sent_o),
    .disc_o     (disc_o),
    .irq_o      (irq_o)
  );

  // frame sequencer and BMC line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      line_q      <= 1'b0;
      oe_q        <= 1'b0;
      half_q      <= 1'b0;
      bcnt_q      <= '0;
      shreg_q     <= '0;
      len_q       <= '0;
      byte_left_q <= '0;
      crc_q       <= '1;
      crc_idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (send_i) begin
          state_q <= ST_WAIT;
          len_q   <= cfg_len_i;
        end
        ST_WAIT: if (gap_ok) begin
          if (line_busy_i) state_q <= ST_IDLE;
          else begin
            state_q     <= ST_PRE;
            line_q      <= 1'b1;
            oe_q        <= 1'b1;
            half_q      <= 1'b0;
            bcnt_q      <= PRE_BITS;
            crc_q       <= '1;
            byte_left_q <= len_q;
          end
        end
        ST_TAIL: if (tick) begin
          state_q <= ST_IDLE;
          oe_q    <= 1'b0;
          line_q  <= 1'b0;
        end
        default: begin
          if (mid_tick) begin
            half_q <= 1'b1;
            if (cur_bit) line_q <= ~line_q;
          end
          if (bnd_tick) begin
            half_q <= 1'b0;
            line_q <= ~line_q;
            if (!seg_last) begin
              bcnt_q  <= bcnt_q - 7'd1;
              shreg_q <= shreg_q >> 1;
            end else begin
              case (state_q)
                ST_PRE: begin
                  state_q <= ST_SOP;
                  shreg_q <= cfg_sop_i;
                  bcnt_q  <= SOP_BITS;
                end
                ST_SOP, ST_DATA: begin
                  bcnt_q <= BYTE_BITS;
                  if (byte_left_q != '0) begin
                    state_q     <= ST_DATA;
                    shreg_q     <= {10'b0, enc_byte(data_q)};
                    byte_left_q <= byte_left_q - 1'b1;
                    crc_q       <= crc32_byte(crc_q, data_q);
                  end else begin
                    state_q   <= ST_CRC;
                    shreg_q   <= {10'b0, enc_byte(crc_out[7:0])};
                    crc_idx_q <= 2'd0;
                  end
                end
                ST_CRC: begin
                  if (crc_idx_q == 2'd3) begin
                    state_q <= ST_EOP;
                    shreg_q <= {15'b0, END_CODE};
                    bcnt_q  <= END_BITS;
                  end else begin
                    crc_idx_q <= crc_idx_nxt;
                    shreg_q   <= {10'b0, enc_byte(crc_nxt_byte)};
                    bcnt_q    <= BYTE_BITS;
                  end
                end
                ST_EOP:  state_q <= ST_TAIL;
                default: ;
              endcase
            end
          end
        end
      endcase
    end
  end

  // payload holding register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q      <= '0;
      data_full_q <= 1'b0;
      req_left_q  <= '0;
    end else begin
      if (start_ev)                     req_left_q <= len_q;
      else if (data_we_i && data_req_o) req_left_q <= req_left_q - 1'b1;
      if (load_byte) data_full_q <= 1'b0;
      else if (data_we_i && !data_full_q) begin
        data_full_q <= 1'b1;
        data_q      <= data_i;
      end
    end
  end

  // half-bits since the last frame ended, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  gcnt_q <= '1;
    else if (end_ev)                              gcnt_q <= '0;
    else if (tick && !in_frame && gcnt_q != '1)   gcnt_q <= gcnt_q + 1'b1;
  end

  assign data_req_o = in_frame && !data_full_q && (req_left_q != '0);
  assign busy_o     = (state_q != ST_IDLE);
  assign cc_o       = line_q;
  assign cc_oe_o    = oe_q;

  // R2
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && !tick) |=> $stable(line_q));

  // R8
  oe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_oe_o |-> busy_o);

  // R4
  byte_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_byte |-> data_full_q);

  // R6
  gap_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cc_oe_o) |-> ($past(gcnt_q) > {1'b0, $past(cfg_gap_i)}));

endmodule

// File: tb/tb_pd_bmc_tx.sv
`timescale 1ns/1ps
module tb_pd_bmc_tx;

  localparam int DIV_W = 8, GAP_W = 8, LEN_W = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_ni;
  logic [DIV_W-1:0] cfg_hbit_div_i;
  logic [GAP_W-1:0] cfg_gap_i;
  logic [19:0]      cfg_sop_i;
  logic [LEN_W-1:0] cfg_len_i;
  logic send_i, line_busy_i, data_we_i, ie_sent_i, ie_disc_i, clr_sent_i, clr_disc_i;
  logic [7:0] data_i;
  logic data_req_o, busy_o, sent_o, disc_o, irq_o, cc_o, cc_oe_o;

  pd_bmc_tx #(.DIV_W(DIV_W), .GAP_W(GAP_W), .LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_hbit_div_i(cfg_hbit_div_i), .cfg_gap_i(cfg_gap_i),
    .cfg_sop_i(cfg_sop_i), .cfg_len_i(cfg_len_i), .send_i(send_i), .line_busy_i(line_busy_i),
    .data_i(data_i), .data_we_i(data_we_i), .data_req_o(data_req_o),
    .ie_sent_i(ie_sent_i), .ie_disc_i(ie_disc_i), .clr_sent_i(clr_sent_i), .clr_disc_i(clr_disc_i),
    .busy_o(busy_o), .sent_o(sent_o), .disc_o(disc_o), .irq_o(irq_o), .cc_o(cc_o), .cc_oe_o(cc_oe_o)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  int feed_en = 0, feed_idx = 0, wr_cnt = 0;
  int nb = 0, rise_cyc = 0, fall_cyc = 0;
  logic [7:0] pl [0:63];
  logic       exp_b [0:1023];
  logic       hb [0:2047];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (feed_en != 0 && data_req_o) begin
      data_we_i = 1'b1;
      data_i    = pl[feed_idx];
      feed_idx++;
      wr_cnt++;
    end else data_we_i = 1'b0;
  end

  initial begin
    wait (cyc > 190000);
    n_fail++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] t_code(input logic [3:0] n);
    logic [4:0] t [0:15];
    t[0]=5'b11110; t[1]=5'b01001; t[2]=5'b10100; t[3]=5'b10101;
    t[4]=5'b01010; t[5]=5'b01011; t[6]=5'b01110; t[7]=5'b01111;
    t[8]=5'b10010; t[9]=5'b10011; t[10]=5'b10110; t[11]=5'b10111;
    t[12]=5'b11010; t[13]=5'b11011; t[14]=5'b11100; t[15]=5'b11101;
    return t[n];
  endfunction

  function automatic logic [31:0] t_crc(input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < len; k++)
      for (int i = 0; i < 8; i++)
        c = ((c[0] ^ pl[k][i]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic add_byte(input logic [7:0] b);
    logic [4:0] lo, hi;
    lo = t_code(b[3:0]); hi = t_code(b[7:4]);
    for (int i = 0; i < 5; i++) begin exp_b[nb] = lo[i]; nb++; end
    for (int i = 0; i < 5; i++) begin exp_b[nb] = hi[i]; nb++; end
  endtask

  task automatic build(input int len, input logic [19:0] sop);
    logic [31:0] c;
    logic [4:0]  eop = 5'b01101;
    nb = 0;
    for (int i = 0; i < 64; i++) begin exp_b[nb] = i[0]; nb++; end
    for (int i = 0; i < 20; i++) begin exp_b[nb] = sop[i]; nb++; end
    for (int k = 0; k < len; k++) add_byte(pl[k]);
    c = t_crc(len);
    for (int k = 0; k < 4; k++) add_byte(c[8*k +: 8]);
    for (int i = 0; i < 5; i++) begin exp_b[nb] = eop[i]; nb++; end
  endtask

  task automatic pulse_send();
    send_i = 1'b1; @(negedge clk); send_i = 1'b0;
  endtask

  // capture one frame at half-bit centres and compare with exp_b
  task automatic capture(input string tag);
    int d, to, bad, bad_i;
    logic prev, bit_v;
    d = int'(cfg_hbit_div_i) + 1;
    to = 0;
    while (!cc_oe_o && to < 20000) begin @(negedge clk); to++; end
    chk(cc_oe_o, "R3 frame start", int'(cc_oe_o), 1);
    rise_cyc = cyc;
    for (int k = 0; k <= 2*nb; k++) begin
      hb[k] = cc_o;
      repeat (d) @(negedge clk);
    end
    fall_cyc = cyc;
    bad = 0; bad_i = -1; prev = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bit_v = hb[2*i] ^ hb[2*i+1];
      if (hb[2*i] == prev || bit_v != exp_b[i]) begin
        if (bad == 0) bad_i = i;
        bad++;
      end
      prev = hb[2*i+1];
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R2/R3/R4/R5 %s: first bad bit %0d actual=%0d expected=%0d",
               tag, bad_i, int'(hb[2*bad_i] ^ hb[2*bad_i+1]), int'(exp_b[bad_i]));
    end
    // R5 tail transition then release
    chk(hb[2*nb] != prev && !cc_oe_o && !cc_o, "R5 tail", int'(cc_oe_o), 0);
  endtask

  task automatic run_frame(input int len, input logic [19:0] sop, input string tag);
    cfg_len_i = LEN_W'(len);
    cfg_sop_i = sop;
    for (int k = 0; k < len; k++) pl[k] = 8'($urandom);
    build(len, sop);
    feed_idx = 0; wr_cnt = 0; feed_en = 1;
    pulse_send();
    capture(tag);
    feed_en = 0;
    chk(wr_cnt == len, "R4 byte requests", wr_cnt, len);
    chk(sent_o && !busy_o, "R9 sent flag", int'(sent_o), 1);
  endtask

  initial begin
    int d, gap_meas, gap_exp, seen;
    void'($urandom(32'h5EED_1234));
    rst_ni = 1'b0; send_i = 0; line_busy_i = 0; data_we_i = 0; data_i = '0;
    ie_sent_i = 0; ie_disc_i = 0; clr_sent_i = 0; clr_disc_i = 0;
    cfg_hbit_div_i = 8'd13; cfg_gap_i = 8'd16; cfg_sop_i = 20'b10001_11000_11000_11000;
    cfg_len_i = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!cc_o && !cc_oe_o && !busy_o && !sent_o && !disc_o && !irq_o && !data_req_o,
        "R1 reset", int'({cc_o, cc_oe_o, busy_o, sent_o, disc_o, irq_o, data_req_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // nominal divider, default start set
    ie_sent_i = 1;
    run_frame(3, 20'b10001_11000_11000_11000, "nominal");
    chk(irq_o, "R10 irq sent", int'(irq_o), 1);
    clr_sent_i = 1; @(negedge clk); clr_sent_i = 0;
    chk(!sent_o && !irq_o, "R9 clear", int'(sent_o), 0);

    // zero-length payload
    run_frame(0, 20'b10001_11000_11000_11000, "empty");   // R11
    clr_sent_i = 1; @(negedge clk); clr_sent_i = 0;

    // fast divider, random frames
    cfg_hbit_div_i = 8'd1; cfg_gap_i = 8'd3;
    for (int n = 0; n < 6; n++) begin
      run_frame(int'($urandom_range(0, 12)), 20'($urandom), "random");
      clr_sent_i = 1; @(negedge clk); clr_sent_i = 0;
    end

    // R8: extra send while busy is ignored
    fork
      run_frame(5, 20'($urandom), "busy send");
      begin repeat (60) @(negedge clk); pulse_send(); end
    join
    seen = 0;
    repeat (200) begin @(negedge clk); if (cc_oe_o || busy_o) seen = 1; end
    chk(seen == 0, "R8 no queued frame", seen, 0);
    clr_sent_i = 1; @(negedge clk); clr_sent_i = 0;

    // R6: back-to-back gap
    cfg_hbit_div_i = 8'd2; cfg_gap_i = 8'd5; d = 3;
    run_frame(2, 20'($urandom), "gap a");
    gap_exp = fall_cyc;
    run_frame(4, 20'($urandom), "gap b");
    gap_meas = rise_cyc - gap_exp;
    chk(gap_meas >= 6*d && gap_meas <= 6*d + 3, "R6 interframe gap", gap_meas, 6*d + 1);
    clr_sent_i = 1; @(negedge clk); clr_sent_i = 0;

    // R7: discard on busy line, with irq enable
    ie_disc_i = 1; line_busy_i = 1; feed_en = 1; wr_cnt = 0; feed_idx = 0;
    cfg_len_i = 6'd4;
    pulse_send();
    seen = 0;
    repeat (400) begin @(negedge clk); if (cc_oe_o || data_req_o) seen = 1; end
    feed_en = 0; line_busy_i = 0;
    chk(seen == 0, "R7 nothing driven", seen, 0);
    chk(disc_o && !busy_o && !sent_o, "R7 discard flag", int'(disc_o), 1);
    chk(irq_o, "R10 irq discard", int'(irq_o), 1);
    ie_disc_i = 0; @(negedge clk);
    chk(!irq_o, "R10 irq masked", int'(irq_o), 0);
    clr_disc_i = 1; @(negedge clk); clr_disc_i = 0;
    chk(!disc_o, "R9 clear discard", int'(disc_o), 0);

    // long frame at nominal divider after discard
    cfg_hbit_div_i = 8'd13; cfg_gap_i = 8'd16;
    run_frame(12, 20'b10001_11000_11000_11000, "long");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule